// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limit Latch

This block sits between a PWM command and the gate-drive stage of a power converter. On every clock it takes a digitized current-sense code and a programmed limit code, forms a trip threshold from them, and decides whether the gate may follow the PWM command. While the sensed current stays below the threshold, the gate output copies the synchronized PWM level. Once the current reaches the threshold, the gate is pulled low at once and a fault flag is latched.

The flag stays set, and the gate stays low, for the rest of the PWM period. This holds even if the sensed current falls again or the PWM command never goes low. The flag clears only on a later rising edge of the PWM command, and only if no trip is present in that cycle. The host can therefore poll the block with a short pulse to learn whether the power stage is safe to drive. A limit set below the fixed offset gives a threshold of zero. The block then trips with no current at all, which is how it comes out of start-up until the host programs a real limit.

Top module: `cbc_limit_guard`

## Requirements
- R1: When no trip is present and the fault flag is low, `gate_out` equals the PWM input after it has passed a two-flop synchronizer. The gate therefore follows `pwm_in` two clock edges later.
- R2: Sense and limit codes are 10-bit unsigned values at 1 mV per LSB. The threshold is min(limit, 1000) minus 25. A trip is present when the registered sense code is greater than or equal to the threshold.
- R3: A trip forces `gate_out` low in the clock cycle that follows the first edge that registers a sense code at or above the threshold.
- R4: A trip sets `fault_flag` at the next clock edge. The flag then stays high until a cycle in which the synchronized PWM shows a rising edge and no trip is present, and it clears at the edge after that cycle. A single-clock PWM pulse is enough to clear it.
- R5: After a trip, `gate_out` stays low while the PWM input stays high, even if the sense code drops below the threshold.
- R6: A limit code below 25 gives a threshold of 0. The block then trips even with a sense code of 0, and it holds the flag until a PWM pulse arrives.
- R7: If a trip and a synchronized PWM rising edge fall in the same cycle, the trip wins: the flag stays set and the gate stays low.
- R8: Synchronous active-high reset clears `fault_flag` and holds `gate_out` low.
- R9: Limit codes above 1000 are clamped to 1000. With limit 1023, a sense of 975 trips and a sense of 974 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command from the host controller, asynchronous to `clk` |
| sense_code | input | 10 | Digitized current-sense value, 1 mV per LSB |
| limit_code | input | 10 | Programmed current limit, 1 mV per LSB |
| gate_out | output | 1 | Gate-drive command |
| fault_flag | output | 1 | Latched overcurrent flag |

## Verification
Directed sequences probe the threshold from both sides. The bench places the sense code at the threshold and one LSB below it, once with a mid-range limit and once with a limit clamped at the ceiling, to show whether the comparison and the clamp are exact. Further sequences hold the PWM input high through a trip and after the sense code falls back, send narrow poll pulses with and without a standing overcurrent, and start from a limit below the offset. Together these tell a proper latch apart from simple gating of the PWM by the trip, and they show that a poll is refused while the fault persists. A long stretch of random PWM, sense and limit values is then compared on every clock against a behavioural model, which exposes the ordering of trip and clear when they come close together.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int CODE_W     = 10;
    localparam int OFFSET_MV  = 25;
    localparam int CEILING_MV = 1000;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t sense;
        code_t limit;
    } meas_t;

    // Saturating threshold: min(limit, ceiling) - offset, floored at zero
    function automatic code_t trip_threshold(code_t limit);
        code_t eff;
        eff = (limit > code_t'(CEILING_MV)) ? code_t'(CEILING_MV) : limit;
        return (eff >= code_t'(OFFSET_MV)) ? code_t'(eff - code_t'(OFFSET_MV)) : '0;
    endfunction

endpackage

// File: rtl/cbc_edge_sync.sv
module cbc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/cbc_trip_detect.sv
module cbc_trip_detect
    import cbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t sense_in,
    input  code_t limit_in,
    output logic  trip
);

    meas_t meas_q;
    code_t thresh;

    always_ff @(posedge clk) begin
        if (rst) meas_q <= '0;
        else begin
            meas_q.sense <= sense_in;
            meas_q.limit <= limit_in;
        end
    end

    always_comb begin
        thresh = trip_threshold(meas_q.limit);
        trip   = (meas_q.sense >= thresh);
    end

endmodule

// File: rtl/cbc_fault_latch.sv
module cbc_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic pwm_rise,
    output logic blocked,
    output logic flag
);

    logic clear_ok;

    always_comb begin
        clear_ok = pwm_rise & ~trip;
        blocked  = trip | (flag & ~clear_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= blocked;
    end

endmodule

// File: rtl/cbc_limit_guard.sv
module cbc_limit_guard
    import cbc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_in,
    input  logic [CODE_W-1:0] sense_code,
    input  logic [CODE_W-1:0] limit_code,
    output logic              gate_out,
    output logic              fault_flag
);

    logic pwm_sync;
    logic pwm_rise;
    logic trip_now;
    logic drive_blocked;

    cbc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pwm_in),
        .level    (pwm_sync),
        .rise     (pwm_rise)
    );

    cbc_trip_detect u_trip (
        .clk      (clk),
        .rst      (rst),
        .sense_in (sense_code),
        .limit_in (limit_code),
        .trip     (trip_now)
    );

    cbc_fault_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .trip     (trip_now),
        .pwm_rise (pwm_rise),
        .blocked  (drive_blocked),
        .flag     (fault_flag)
    );

    assign gate_out = ~rst & pwm_sync & ~drive_blocked;

endmodule

// File: rtl/cbc_limit_guard_chk.sv
module cbc_limit_guard_chk (
    input logic clk,
    input logic rst,
    input logic gate,
    input logic flag,
    input logic trip,
    input logic rise,
    input logic pwm_lvl
);

    p_follow_r1: assert property (@(posedge clk) disable iff (rst)
        (!trip && !flag) |-> (gate == pwm_lvl));

    p_trip_low_r3: assert property (@(posedge clk) disable iff (rst)
        trip |-> !gate);

    p_trip_sets_r4: assert property (@(posedge clk) disable iff (rst)
        trip |=> flag);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (flag && !rise) |-> (!gate ##1 flag));

    p_poll_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && rise && !trip) |=> !flag);

    p_trip_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && rise && trip) |=> flag);

    p_reset_r8: assert property (@(posedge clk)
        rst |=> !flag);

    p_reset_gate_r8: assert property (@(posedge clk)
        rst |-> !gate);

endmodule

bind cbc_limit_guard cbc_limit_guard_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .gate    (gate_out),
    .flag    (fault_flag),
    .trip    (trip_now),
    .rise    (pwm_rise),
    .pwm_lvl (pwm_sync)
);

// File: tb/test_cbc_limit_guard.sv
module test_cbc_limit_guard;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic [9:0] sense_code = '0;
    logic [9:0] limit_code = '0;
    logic       gate_out;
    logic       fault_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit started  = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    cbc_limit_guard i_cbc_limit_guard (
        .clk        (clk),
        .rst        (rst),
        .pwm_in     (pwm_in),
        .sense_code (sense_code),
        .limit_code (limit_code),
        .gate_out   (gate_out),
        .fault_flag (fault_flag)
    );

    // Behavioural reference: PWM delay line, registered samples, latched flag
    bit pwm_q[$];
    int m_sense, m_limit;
    bit m_flag, m_block, exp_gate;

    function automatic int thr_of(int lim);
        int e = (lim > 1000) ? 1000 : lim;
        return (e < 25) ? 0 : e - 25;
    endfunction

    always @(posedge clk) begin
        bit trip, rise, lvl, prev;
        started = 1;
        if (rst) begin
            pwm_q = '{0, 0, 0};
            m_sense = 0; m_limit = 0; m_flag = 0;
        end else begin
            m_flag = m_block;
            pwm_q.push_front(pwm_in);
            void'(pwm_q.pop_back());
            m_sense = sense_code;
            m_limit = limit_code;
        end
        lvl  = pwm_q[1];
        prev = pwm_q[2];
        trip = (m_sense >= thr_of(m_limit));
        rise = lvl && !prev;
        m_block  = trip || (m_flag && !(rise && !trip));
        exp_gate = !rst && lvl && !m_block;
    end

    task automatic chk(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk(m_block ? "R3 gate" : "R1 gate", gate_out, exp_gate);
            chk("R4 flag", fault_flag, m_flag);
        end
    end

    task automatic drive(logic p, int s, int l);
        @(negedge clk); #1;
        pwm_in = p; sense_code = 10'(s); limit_code = 10'(l);
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #0.5;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R8 reset
        wait_n(3);
        chk("R8 flag", fault_flag, 1'b0);
        chk("R8 gate", gate_out, 1'b0);
        drive(0, 0, 0);
        rst = 1'b0;
        // R6 zero limit trips with zero sense
        wait_n(3);
        chk("R6 flag", fault_flag, 1'b1);
        // R4 narrow poll pulse clears with limit 500
        drive(0, 0, 500);
        drive(1, 0, 500);
        drive(0, 0, 500);
        wait_n(4);
        chk("R4 poll", fault_flag, 1'b0);
        // R1 follow
        drive(1, 100, 500);
        wait_n(3);
        chk("R1 gate", gate_out, 1'b1);
        // R2 one below threshold (475)
        drive(1, 474, 500);
        wait_n(2);
        chk("R2 below", gate_out, 1'b1);
        chk("R2 below flag", fault_flag, 1'b0);
        // R3 at threshold
        drive(1, 475, 500);
        wait_n(1);
        chk("R3 trip gate", gate_out, 1'b0);
        wait_n(1);
        chk("R2 at flag", fault_flag, 1'b1);
        // R5 sense falls, pwm high
        drive(1, 0, 500);
        wait_n(20);
        chk("R5 gate", gate_out, 1'b0);
        chk("R5 flag", fault_flag, 1'b1);
        // new pwm period clears
        drive(0, 0, 500);
        wait_n(2);
        drive(1, 0, 500);
        wait_n(4);
        chk("R4 clear", fault_flag, 1'b0);
        chk("R4 gate", gate_out, 1'b1);
        // R9 clamp
        drive(1, 974, 1023);
        wait_n(2);
        chk("R9 974", gate_out, 1'b1);
        drive(1, 975, 1023);
        wait_n(2);
        chk("R9 975", fault_flag, 1'b1);
        // R7 rising edge while trip persists
        drive(0, 975, 1023);
        wait_n(2);
        drive(1, 975, 1023);
        wait_n(5);
        chk("R7 flag", fault_flag, 1'b1);
        chk("R7 gate", gate_out, 1'b0);
        // random stretch compared every clock
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 9));
            drive(r < 5, int'($urandom_range(0, 1023)) % ((r == 0) ? 1024 : 600),
                  (r == 9) ? int'($urandom_range(0, 40)) : int'($urandom_range(300, 1023)));
        end
        wait_n(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule